// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges every reason the chip may need to restart into one internal reset and shapes that reset in time. The reasons are power-on, a shared open-drain reset pad that outside devices can pull low, a watchdog expiry request, a low-voltage detector event, an illegal-opcode trap and an illegal-address trap. Power-on comes in on the block's asynchronous reset. The other sources arrive as strobes or as a level. Only the watchdog request is not aligned to the clock, so it is synchronized first.

For a cause raised inside the chip, the block drives the pad low for a fixed number of oscillator clocks so that outside devices reset too. It then keeps the internal reset asserted for a second fixed stretch. Power-on and low-voltage causes first hold the pad low for a long stabilisation stretch, and the two normal phases follow. An outside pull on the pad holds the internal reset only for as long as the pad stays low.

A sticky status register records which causes occurred and clears on a read strobe. A flag tells the rest of the chip whether the shared system counter must be cleared. The block presents the reset vector address pair and raises a one-cycle pulse when the CPU may fetch from it.

Top module: `reset_sequencer`

## Requirements
- R1: After power-on reset is released, `status` reads 6'b000001 and `pad_oe`, `int_rst` and `clr_sys_cnt` are high. `pad_oe` stays high for STAB_CYC+DRIVE_CYC cycles, `int_rst` stays high for HOLD_CYC more, and `fetch_go` pulses in the first cycle after release of `int_rst` (cycle 4160 counting clock edges after release, with defaults).
- R2: An illegal-opcode, illegal-address or watchdog cause sampled at a clock edge makes `pad_oe` high for the next DRIVE_CYC cycles. `int_rst` then stays high for HOLD_CYC further cycles, and `fetch_go` is high for exactly one cycle right after `int_rst` falls.
- R3: A low-voltage strobe starts a stabilisation phase of STAB_CYC cycles with `pad_oe` and `int_rst` high, and the R2 sequence follows.
- R4: Status bits are sticky, and each cause sets its own bit: bit 0 power-on, bit 1 external pin, bit 2 watchdog, bit 3 low-voltage, bit 4 illegal opcode, bit 5 illegal address.
- R5: `stat_rd` high at a clock edge clears every status bit, but a cause that sets a bit at the same edge leaves that bit set.
- R6: When the synchronized pad is low and no internal sequence is running, `int_rst` is high and `clr_sys_cnt` is low. Bit 1 is set only if the pad stayed low for at least PIN_MIN consecutive clocks. `fetch_go` pulses on the edge after the synchronized pad reads high again.
- R7: `clr_sys_cnt` is high throughout every internally caused sequence.
- R8: With `monitor_mode` low, `vec_hi_addr` is 16'hFFFE and `vec_lo_addr` is 16'hFFFF. With it high, they are 16'hFEFE and 16'hFEFF.
- R9: An illegal-opcode, illegal-address or watchdog cause during the drive or hold phase restarts the drive phase. A low-voltage strobe in any phase restarts stabilisation. During stabilisation, a non-low-voltage cause only sets its status bit.
- R10: The watchdog request passes through a two-flop synchronizer and acts on its rising edge. A request raised just after edge c starts the sequence at edge c+3.
- R11: While the block runs an internal sequence, a low pad is ignored. It sets no status bit and changes no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pad_in | input | 1 | Sensed level of the reset pad |
| pad_oe | output | 1 | High drives the reset pad low (open-drain) |
| wdog_req | input | 1 | Watchdog expiry request, asynchronous level |
| lvi_evt | input | 1 | Low-voltage detect strobe |
| bad_op_evt | input | 1 | Illegal-opcode strobe |
| bad_addr_evt | input | 1 | Illegal-address strobe |
| monitor_mode | input | 1 | Selects the alternate vector pair |
| stat_rd | input | 1 | Status read strobe, clears the status |
| status | output | 6 | Sticky reset-cause bits |
| int_rst | output | 1 | Internal reset to the rest of the chip |
| clr_sys_cnt | output | 1 | Shared system counter must be cleared |
| vec_hi_addr | output | 16 | Address of the vector high byte |
| vec_lo_addr | output | 16 | Address of the vector low byte |
| fetch_go | output | 1 | One-cycle pulse: fetch the reset vector |

## Verification
A status read and a new cause can land on the same clock edge. The read wants every bit cleared, and the cause wants its own bit set. The bench raises `stat_rd` and the illegal-address strobe in the same cycle while an older cause bit is still set. It then judges that only the new bit survives, both right after the edge and when the scoreboard compares the status at the vector fetch. A restart cause arriving in the same window as the end of a phase is provoked the same way, and it is judged by the cycle at which `fetch_go` shows up.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  localparam int NCAUSE = 6;
  localparam int CS_POR  = 0;
  localparam int CS_PIN  = 1;
  localparam int CS_WDOG = 2;
  localparam int CS_LVI  = 3;
  localparam int CS_OPC  = 4;
  localparam int CS_ADR  = 5;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_STAB  = 3'd1,
    PH_DRIVE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_PIN   = 3'd4
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic [15:0] vec_base(input logic mon);
    return mon ? 16'hFEFE : 16'hFFFE;
  endfunction

  function automatic logic [NCAUSE-1:0] log_next(input logic [NCAUSE-1:0] cur,
                                                 input logic [NCAUSE-1:0] set,
                                                 input logic rd);
    return (rd ? '0 : cur) | set;
  endfunction

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rseq_cause_log.sv
module rseq_cause_log
  import rseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] set_vec,
  input  logic              rd,
  output logic [NCAUSE-1:0] status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status         <= '0;
      status[CS_POR] <= 1'b1;
    end else begin
      status <= log_next(status, set_vec, rd);
    end
  end
endmodule

// File: rtl/rseq_phase_fsm.sv
module rseq_phase_fsm
  import rseq_pkg::*;
#(
  parameter int STAB_CYC  = 4096,
  parameter int DRIVE_CYC = 32,
  parameter int HOLD_CYC  = 32,
  parameter int PIN_MIN   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvi_evt,
  input  logic fault_evt,
  input  logic pin_low,
  output logic int_rst,
  output logic pad_oe,
  output logic src_internal,
  output logic pin_hit,
  output logic fetch_go
);
  localparam int CW = $clog2(max3(STAB_CYC, DRIVE_CYC, HOLD_CYC)) + 1;
  localparam int PW = $clog2(PIN_MIN + 1) + 1;
  localparam logic [CW-1:0] STAB_END  = CW'(STAB_CYC - 1);
  localparam logic [CW-1:0] DRIVE_END = CW'(DRIVE_CYC - 1);
  localparam logic [CW-1:0] HOLD_END  = CW'(HOLD_CYC - 1);
  localparam logic [PW-1:0] PIN_SAT   = PW'(PIN_MIN);
  localparam logic [PW-1:0] PIN_LAST  = PW'(PIN_MIN - 1);

  phase_e        ph, ph_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [PW-1:0] pcnt, pcnt_n;
  logic          intl, intl_n, go_n;

  always_comb begin
    ph_n    = ph;
    cnt_n   = cnt + 1'b1;
    pcnt_n  = pcnt;
    intl_n  = intl;
    go_n    = 1'b0;
    pin_hit = 1'b0;
    unique case (ph)
      PH_IDLE, PH_PIN: begin
        if (lvi_evt) begin
          ph_n = PH_STAB; cnt_n = '0; intl_n = 1'b1;
        end else if (fault_evt) begin
          ph_n = PH_DRIVE; cnt_n = '0; intl_n = 1'b1;
        end else if (pin_low) begin
          ph_n   = PH_PIN;
          intl_n = 1'b0;
          if (ph == PH_IDLE) begin
            pcnt_n  = PW'(1);
            pin_hit = (PIN_MIN <= 1);
          end else begin
            pcnt_n  = (pcnt == PIN_SAT) ? pcnt : pcnt + 1'b1;
            pin_hit = (pcnt == PIN_LAST);
          end
        end else if (ph == PH_PIN) begin
          ph_n = PH_IDLE; go_n = 1'b1;
        end
      end
      PH_STAB: begin
        if (lvi_evt) cnt_n = '0;
        else if (cnt == STAB_END) begin
          ph_n = PH_DRIVE; cnt_n = '0;
        end
      end
      PH_DRIVE, PH_HOLD: begin
        if (lvi_evt) begin
          ph_n = PH_STAB; cnt_n = '0;
        end else if (fault_evt) begin
          ph_n = PH_DRIVE; cnt_n = '0;
        end else if (ph == PH_DRIVE && cnt == DRIVE_END) begin
          ph_n = PH_HOLD; cnt_n = '0;
        end else if (ph == PH_HOLD && cnt == HOLD_END) begin
          ph_n = PH_IDLE; cnt_n = '0; go_n = 1'b1;
        end
      end
      default: begin
        ph_n = PH_IDLE; cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_STAB;
      cnt      <= '0;
      pcnt     <= '0;
      intl     <= 1'b1;
      fetch_go <= 1'b0;
    end else begin
      ph       <= ph_n;
      cnt      <= cnt_n;
      pcnt     <= pcnt_n;
      intl     <= intl_n;
      fetch_go <= go_n;
    end
  end

  assign int_rst      = (ph != PH_IDLE);
  assign pad_oe       = (ph == PH_STAB) || (ph == PH_DRIVE);
  assign src_internal = intl;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rseq_pkg::*;
#(
  parameter int STAB_CYC  = 4096,
  parameter int DRIVE_CYC = 32,
  parameter int HOLD_CYC  = 32,
  parameter int PIN_MIN   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_in,
  output logic              pad_oe,
  input  logic              wdog_req,
  input  logic              lvi_evt,
  input  logic              bad_op_evt,
  input  logic              bad_addr_evt,
  input  logic              monitor_mode,
  input  logic              stat_rd,
  output logic [NCAUSE-1:0] status,
  output logic              int_rst,
  output logic              clr_sys_cnt,
  output logic [15:0]       vec_hi_addr,
  output logic [15:0]       vec_lo_addr,
  output logic              fetch_go
);
  logic pad_sync, wd_sync, wd_prev, wd_rise, fault_evt, pin_low;
  logic src_internal, pin_hit;
  logic [NCAUSE-1:0] set_vec;

  rseq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_pad_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync));

  rseq_sync #(.STAGES(2), .RST_VAL(1'b0)) u_wd_sync (
    .clk(clk), .rst_n(rst_n), .d(wdog_req), .q(wd_sync));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_prev <= 1'b0;
    else        wd_prev <= wd_sync;
  end

  assign wd_rise   = wd_sync & ~wd_prev;
  assign pin_low   = ~pad_sync;
  assign fault_evt = bad_op_evt | bad_addr_evt | wd_rise;

  rseq_phase_fsm #(
    .STAB_CYC(STAB_CYC), .DRIVE_CYC(DRIVE_CYC),
    .HOLD_CYC(HOLD_CYC), .PIN_MIN(PIN_MIN)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .lvi_evt(lvi_evt), .fault_evt(fault_evt),
    .pin_low(pin_low), .int_rst(int_rst), .pad_oe(pad_oe),
    .src_internal(src_internal), .pin_hit(pin_hit), .fetch_go(fetch_go));

  always_comb begin
    set_vec          = '0;
    set_vec[CS_PIN]  = pin_hit;
    set_vec[CS_WDOG] = wd_rise;
    set_vec[CS_LVI]  = lvi_evt;
    set_vec[CS_OPC]  = bad_op_evt;
    set_vec[CS_ADR]  = bad_addr_evt;
  end

  rseq_cause_log u_log (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd(stat_rd), .status(status));

  assign clr_sys_cnt = int_rst & src_internal;
  assign vec_hi_addr = vec_base(monitor_mode);
  assign vec_lo_addr = vec_base(monitor_mode) | 16'h0001;
endmodule

// File: rtl/rseq_checker.sv
module rseq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        pad_oe,
  input logic        int_rst,
  input logic        clr_sys_cnt,
  input logic        fetch_go,
  input logic        stat_rd,
  input logic        monitor_mode,
  input logic [5:0]  status,
  input logic [5:0]  set_vec,
  input logic        wd_rise,
  input logic [15:0] vec_hi_addr,
  input logic [15:0] vec_lo_addr
);
  assert_pad_implies_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> int_rst) else $error("pad driven without internal reset");

  assert_go_after_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> (!int_rst && $past(int_rst))) else $error("fetch pulse misplaced");

  assert_go_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> !fetch_go) else $error("fetch pulse longer than one cycle");

  assert_clr_while_driving_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> clr_sys_cnt) else $error("counter clear missing during drive");

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status & $past(status)) == $past(status))) else $error("status bit lost");

  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && set_vec == 6'd0) |=> (status == 6'd0)) else $error("read did not clear");

  assert_pin_bit_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> int_rst) else $error("pin bit set outside reset");

  assert_vec_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_lo_addr == (vec_hi_addr + 16'd1)) else $error("vector pair not adjacent");

  assert_vec_monitor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    monitor_mode |-> (vec_hi_addr == 16'hFEFE)) else $error("monitor vector wrong");

  assert_wdog_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rise |=> int_rst) else $error("watchdog edge did not reset");
endmodule

bind reset_sequencer rseq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pad_oe(pad_oe), .int_rst(int_rst),
  .clr_sys_cnt(clr_sys_cnt), .fetch_go(fetch_go), .stat_rd(stat_rd),
  .monitor_mode(monitor_mode), .status(status), .set_vec(set_vec),
  .wd_rise(wd_rise), .vec_hi_addr(vec_hi_addr), .vec_lo_addr(vec_lo_addr));

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb;
  localparam int PMIN = 8;

  logic clk = 0, rst_n = 0, ext_low = 0;
  logic wdog_req = 0, lvi_evt = 0, bad_op_evt = 0, bad_addr_evt = 0;
  logic monitor_mode = 0, stat_rd = 0;
  logic pad_in, pad_oe, int_rst, clr_sys_cnt, fetch_go;
  logic [5:0] status;
  logic [15:0] vec_hi_addr, vec_lo_addr;

  int cyc, n_cmp, n_bad;

  typedef struct { int at; logic [5:0] st; string req; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  assign pad_in = ~(pad_oe | ext_low);

  reset_sequencer #(.PIN_MIN(PMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_oe(pad_oe),
    .wdog_req(wdog_req), .lvi_evt(lvi_evt), .bad_op_evt(bad_op_evt),
    .bad_addr_evt(bad_addr_evt), .monitor_mode(monitor_mode), .stat_rd(stat_rd),
    .status(status), .int_rst(int_rst), .clr_sys_cnt(clr_sys_cnt),
    .vec_hi_addr(vec_hi_addr), .vec_lo_addr(vec_lo_addr), .fetch_go(fetch_go));

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Monitor: pops one expected fetch per observed fetch pulse
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && fetch_go) begin
      n_cmp++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: fetch_go at cycle %0d, expected none", cyc);
      end else begin
        e = sb_q.pop_front();
        if (cyc != e.at || status != e.st) begin
          n_bad++;
          $display("FAIL %s: fetch at %0d status %b, expected at %0d status %b",
                   e.req, cyc, status, e.at, e.st);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: cycle %0d got %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic expect_fetch(input int at, input logic [5:0] st, input string req);
    exp_t e;
    e.at = at; e.st = st; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic read_clear();
    stat_rd = 1; @(negedge clk); stat_rd = 0; @(negedge clk);
  endtask

  task automatic finish_run();
    n_cmp++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d fetches missing, expected 0", sb_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int c;
    n_cmp = 0; n_bad = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: power-on state and sequence
    chk("R1 status", 32'(status), 32'h01);
    chk("R1 pad_oe", 32'(pad_oe), 1);
    chk("R1 clr", 32'(clr_sys_cnt), 1);
    expect_fetch(4160, 6'b000001, "R1");
    wait_until(4127); chk("R1 pad end", 32'(pad_oe), 1);
    wait_until(4128); chk("R1 hold", 32'({pad_oe, int_rst}), 32'b01);
    wait_until(4161); chk("R1 released", 32'(int_rst), 0);
    // R8: vector pairs
    chk("R8 normal", {vec_hi_addr, vec_lo_addr}, 32'hFFFEFFFF);
    monitor_mode = 1; @(negedge clk);
    chk("R8 monitor", {vec_hi_addr, vec_lo_addr}, 32'hFEFEFEFF);
    monitor_mode = 0;
    // R5: read clears
    read_clear(); chk("R5 cleared", 32'(status), 0);
    // R2 + R11: illegal opcode, pad pulled from outside during drive
    c = cyc; expect_fetch(c + 65, 6'b010000, "R2/R11");
    bad_op_evt = 1; @(negedge clk); bad_op_evt = 0;
    chk("R7 clr", 32'(clr_sys_cnt), 1);
    wait_until(c + 5); ext_low = 1;
    wait_until(c + 15); ext_low = 0;
    wait_until(c + 32); chk("R2 drive last", 32'(pad_oe), 1);
    wait_until(c + 33); chk("R2 hold first", 32'({pad_oe, int_rst}), 32'b01);
    wait_until(c + 64); chk("R2 hold last", 32'(int_rst), 1);
    wait_until(c + 66); chk("R11 no pin bit", 32'(status), 32'h10);
    // R5: read and new cause in the same cycle
    c = cyc; expect_fetch(c + 65, 6'b100000, "R5");
    stat_rd = 1; bad_addr_evt = 1; @(negedge clk); stat_rd = 0; bad_addr_evt = 0;
    chk("R5 same edge", 32'(status), 32'h20);
    wait_until(c + 67); read_clear();
    // R9: restart in drive and in hold
    c = cyc; expect_fetch(c + 75, 6'b010000, "R9 drive");
    bad_op_evt = 1; @(negedge clk); bad_op_evt = 0;
    wait_until(c + 10); bad_op_evt = 1; @(negedge clk); bad_op_evt = 0;
    wait_until(c + 42); chk("R9 drive restart", 32'(pad_oe), 1);
    wait_until(c + 43); chk("R9 drive end", 32'(pad_oe), 0);
    wait_until(c + 77); read_clear();
    c = cyc; expect_fetch(c + 105, 6'b010000, "R9 hold");
    bad_op_evt = 1; @(negedge clk); bad_op_evt = 0;
    wait_until(c + 40); chk("R9 in hold", 32'(pad_oe), 0);
    bad_op_evt = 1; @(negedge clk); bad_op_evt = 0;
    chk("R9 hold restart", 32'(pad_oe), 1);
    wait_until(c + 107); read_clear();
    // R3 + R9: low voltage with a fault during stabilisation
    c = cyc; expect_fetch(c + 4161, 6'b101000, "R3/R9");
    lvi_evt = 1; @(negedge clk); lvi_evt = 0;
    wait_until(c + 100); bad_addr_evt = 1; @(negedge clk); bad_addr_evt = 0;
    wait_until(c + 4128); chk("R3 drive last", 32'({pad_oe, clr_sys_cnt}), 32'b11);
    wait_until(c + 4129); chk("R3 hold", 32'(pad_oe), 0);
    wait_until(c + 4163); read_clear();
    // R10: watchdog through synchronizer
    c = cyc; expect_fetch(c + 67, 6'b000100, "R10");
    wdog_req = 1;
    wait_until(c + 2); chk("R10 not yet", 32'(int_rst), 0);
    wait_until(c + 3); chk("R10 started", 32'(int_rst), 1);
    wait_until(c + 5); wdog_req = 0;
    wait_until(c + 69); read_clear();
    // R6: short pin pulse, below minimum
    c = cyc; expect_fetch(c + PMIN - 1 + 3, 6'b000000, "R6 short");
    ext_low = 1;
    wait_until(c + 2); chk("R6 not yet", 32'(int_rst), 0);
    wait_until(c + 3); chk("R6 pin reset", 32'({int_rst, clr_sys_cnt}), 32'b10);
    wait_until(c + PMIN - 1); ext_low = 0;
    wait_until(c + PMIN + 4);
    // R6: pulse exactly at minimum
    c = cyc; expect_fetch(c + PMIN + 3, 6'b000010, "R6 min");
    ext_low = 1;
    wait_until(c + PMIN); ext_low = 0;
    wait_until(c + PMIN + 5);
    chk("R6 bit kept", 32'(status), 32'h02);
    finish_run();
  end
endmodule